// File: doc/BRIEF.md
# Phase-Aligned Dot-Clock Divider

This block turns one dot clock into three derived clocks: a reference clock that never stops, a shift clock that follows the reference clock but is silenced while the display is blanked, and a video timing clock. Each derived clock can be the dot clock itself or the dot clock divided by a power of two up to 64. The shift clock can also be turned off at logic 0, and the video clock can be parked at logic 1.

Every divided output is a bit of one shared six-stage counter. The counter steps down by one on each rising dot-clock edge, so a slower output only ever rises on a rising edge of every faster output. A one-cycle write of the all-ones word to the selection port does not load the selection. Instead it clears the shared counter. Several devices can use this to line up their clock phases, with all divided outputs starting low and rising together on the following edge. The selection port is a plain strobe and data pair sampled on the dot clock; it has no handshake and no back-pressure.

Top module: `dotclk_divider`

## Requirements
- R1: After reset the selection word is all ones. The reference clock runs at the dot clock divided by 64, the shift clock is at 0 and the video clock is at 1.
- R2: Selection bits [2:0] pick the reference rate. A code k from 0 to 6 gives the dot clock divided by 2^k, where k = 0 means the dot clock itself. Code 7 also gives divide by 64.
- R3: Selection bits [5:3] pick the video rate. Codes 0 to 6 work as in R2. Code 7 holds the video clock at 1.
- R4: Every rising edge of a divided output coincides with a rising edge of every faster divided output.
- R5: The reference clock keeps toggling at its selected rate while blank is high.
- R6: While blank is low, the shift clock equals the reference clock. The gate only opens or closes while the reference clock is low, so every shift pulse it lets through is a complete pulse.
- R7: Reference code 7 holds the shift clock at 0.
- R8: A write of 6'h3F leaves the selection unchanged and clears the counter. After that edge all divided outputs are low, and on the next edge they all rise together.
- R9: Blank is registered on the dot clock. The shift clock stops within 2 + 64 dot cycles of blank going high and restarts once blank is low again.
- R10: A write of any other value takes effect from the dot edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dot_clk | input | 1 | Dot clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| blank | input | 1 | High while the display is blanked |
| sel_wr | input | 1 | One-cycle write strobe for the selection word |
| sel_data | input | 6 | Selection word; [2:0] reference/shift code, [5:3] video code, 6'h3F = counter clear |
| ref_clk | output | 1 | Free-running reference clock |
| shift_clk | output | 1 | Blank-gated copy of the reference clock |
| vid_clk | output | 1 | Video timing clock |

## Verification
The assertions assume the following about the inputs. Blank and the selection strobe are synchronous to the dot clock. The edge-alignment and clean-gating checks only cover cycles in which the selection has not just changed, because a rate change may legally cut a pulse short. The bench changes every input two nanoseconds after a falling dot edge. It holds blank for many cycles at a time and leaves settle time after each write, so each measurement covers whole periods of a stable configuration.

// File: rtl/dotclk_pkg.sv
package dotclk_pkg;
  // Which output a divider tap feeds; picks the meaning of the hold code.
  typedef enum logic {
    TAP_REF = 1'b0,
    TAP_VID = 1'b1
  } tap_kind_e;

  localparam int unsigned DEF_CODE_W = 3;
endpackage

// File: rtl/dotclk_selreg.sv
module dotclk_selreg #(
  parameter int unsigned CODE_W = dotclk_pkg::DEF_CODE_W,
  localparam int unsigned SEL_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [SEL_W-1:0]  wdata,
  output logic [CODE_W-1:0] ref_code,
  output logic [CODE_W-1:0] vid_code,
  output logic              sync_clr
);
  logic [SEL_W-1:0] sel_q;

  // The all-ones word is a command, not a setting.
  assign sync_clr = wr && (&wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '1;
    end else if (wr && !sync_clr) begin
      sel_q <= wdata;
    end
  end

  assign ref_code = sel_q[CODE_W-1:0];
  assign vid_code = sel_q[SEL_W-1:CODE_W];
endmodule

// File: rtl/dotclk_counter.sv
module dotclk_counter #(
  parameter int unsigned STAGES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  output logic [STAGES-1:0] cnt
);
  // Counting down makes every bit rise on the same edge as all lower bits.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dotclk_tap.sv
module dotclk_tap
  import dotclk_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned STAGES = (1 << CODE_W) - 2,
  parameter tap_kind_e   KIND   = TAP_REF
) (
  input  logic              dot_clk,
  input  logic [STAGES-1:0] cnt,
  input  logic [CODE_W-1:0] code,
  output logic              clk_o
);
  localparam logic [CODE_W-1:0] HOLD = '1;

  logic tap_bit;
  logic hold_val;

  always_comb begin
    tap_bit = 1'b0;
    for (int i = 1; i <= int'(STAGES); i++) begin
      if (code == CODE_W'(i)) tap_bit = cnt[i-1];
    end
  end

  generate
    if (KIND == TAP_REF) begin : g_ref
      assign hold_val = cnt[STAGES-1];
    end else begin : g_vid
      assign hold_val = 1'b1;
    end
  endgenerate

  always_comb begin
    if (code == '0) begin
      clk_o = dot_clk;
    end else if (code == HOLD) begin
      clk_o = hold_val;
    end else begin
      clk_o = tap_bit;
    end
  end
endmodule

// File: rtl/dotclk_shift_gate.sv
module dotclk_shift_gate (
  input  logic dot_clk,
  input  logic rst,
  input  logic blank,
  input  logic ref_clk,
  input  logic ref_is_dot,
  input  logic shift_off,
  output logic shift_clk
);
  logic blank_q;
  logic open_q;

  always_ff @(posedge dot_clk) begin
    if (rst) blank_q <= 1'b1;
    else     blank_q <= blank;
  end

  // The gate changes on the falling dot edge and only while the reference is low.
  always_ff @(negedge dot_clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (ref_is_dot || !ref_clk) begin
      open_q <= !blank_q;
    end
  end

  assign shift_clk = ref_clk && open_q && !shift_off;
endmodule

// File: rtl/dotclk_divider.sv
module dotclk_divider
  import dotclk_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned SEL_W  = 2 * CODE_W,
  localparam int unsigned STAGES = (1 << CODE_W) - 2
) (
  input  logic             dot_clk,
  input  logic             rst,
  input  logic             blank,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_data,
  output logic             ref_clk,
  output logic             shift_clk,
  output logic             vid_clk
);
  localparam logic [CODE_W-1:0] HOLD = '1;

  logic [CODE_W-1:0] ref_code;
  logic [CODE_W-1:0] vid_code;
  logic              sync_clr;
  logic [STAGES-1:0] cnt;

  dotclk_selreg #(.CODE_W(CODE_W)) u_sel (
    .clk(dot_clk), .rst(rst), .wr(sel_wr), .wdata(sel_data),
    .ref_code(ref_code), .vid_code(vid_code), .sync_clr(sync_clr)
  );

  dotclk_counter #(.STAGES(STAGES)) u_cnt (
    .clk(dot_clk), .rst(rst), .clr(sync_clr), .cnt(cnt)
  );

  dotclk_tap #(.CODE_W(CODE_W), .STAGES(STAGES), .KIND(TAP_REF)) u_ref_tap (
    .dot_clk(dot_clk), .cnt(cnt), .code(ref_code), .clk_o(ref_clk)
  );

  dotclk_tap #(.CODE_W(CODE_W), .STAGES(STAGES), .KIND(TAP_VID)) u_vid_tap (
    .dot_clk(dot_clk), .cnt(cnt), .code(vid_code), .clk_o(vid_clk)
  );

  dotclk_shift_gate u_gate (
    .dot_clk(dot_clk), .rst(rst), .blank(blank), .ref_clk(ref_clk),
    .ref_is_dot(ref_code == '0), .shift_off(ref_code == HOLD),
    .shift_clk(shift_clk)
  );
endmodule

// File: rtl/dotclk_divider_chk.sv
module dotclk_divider_chk #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned SEL_W  = 2 * CODE_W,
  localparam int unsigned STAGES = (1 << CODE_W) - 2,
  localparam int unsigned RUN_W  = STAGES + 2
) (
  input logic              dot_clk,
  input logic              rst,
  input logic              blank,
  input logic              sel_wr,
  input logic [SEL_W-1:0]  sel_data,
  input logic              ref_clk,
  input logic              shift_clk,
  input logic              vid_clk,
  input logic [CODE_W-1:0] ref_code,
  input logic [CODE_W-1:0] vid_code
);
  localparam logic [CODE_W-1:0] HOLD  = '1;
  localparam logic [SEL_W-1:0]  SYNC  = '1;
  localparam logic [RUN_W-1:0]  LIMIT = RUN_W'(2 + (1 << STAGES));

  logic [CODE_W-1:0] ref_eff;
  logic              codes_still;
  logic              sync_wr;
  logic [RUN_W-1:0]  blank_run;

  assign ref_eff = (ref_code == HOLD) ? CODE_W'(STAGES) : ref_code;
  assign sync_wr = sel_wr && (sel_data == SYNC);

  always_ff @(posedge dot_clk) begin
    if (rst || !blank)      blank_run <= '0;
    else if (blank_run != '1) blank_run <= blank_run + 1'b1;
  end

  always_ff @(posedge dot_clk) begin
    if (rst) codes_still <= 1'b0;
    else     codes_still <= 1'b1;
  end

  a_r4_edges_aligned: assert property (@(posedge dot_clk) disable iff (rst)
    (codes_still && $rose(vid_clk) && ref_code != '0 && vid_code != '0 && vid_code != HOLD
     && ref_eff <= vid_code && $stable(ref_code) && $stable(vid_code))
    |-> $rose(ref_clk));

  a_r6_shift_rise_clean: assert property (@(posedge dot_clk) disable iff (rst)
    (codes_still && $rose(shift_clk) && ref_code != '0 && $stable(ref_code))
    |-> $rose(ref_clk));

  a_r6_shift_fall_clean: assert property (@(posedge dot_clk) disable iff (rst)
    (codes_still && $fell(shift_clk) && ref_code != '0 && $stable(ref_code))
    |-> $fell(ref_clk));

  a_r7_shift_off_low: assert property (@(posedge dot_clk) disable iff (rst)
    (sel_wr && sel_data[CODE_W-1:0] == HOLD && !sync_wr) |=> !shift_clk);

  a_r3_vid_hold_high: assert property (@(posedge dot_clk) disable iff (rst)
    (sel_wr && sel_data[SEL_W-1:CODE_W] == HOLD && !sync_wr) |=> vid_clk);

  a_r8_clear_low: assert property (@(posedge dot_clk) disable iff (rst)
    sync_wr |=> ((ref_code == '0 || !ref_clk)
                 && (vid_code == '0 || vid_code == HOLD || !vid_clk)));

  a_r8_sel_kept: assert property (@(posedge dot_clk) disable iff (rst)
    sync_wr |=> ($stable(ref_code) && $stable(vid_code)));

  a_r10_write_loads: assert property (@(posedge dot_clk) disable iff (rst)
    (sel_wr && !sync_wr) |=> ({vid_code, ref_code} == $past(sel_data)));

  a_r9_blank_stops: assert property (@(posedge dot_clk) disable iff (rst)
    (blank_run >= LIMIT) |-> !shift_clk);
endmodule

bind dotclk_divider dotclk_divider_chk #(.CODE_W(CODE_W)) u_chk (
  .dot_clk(dot_clk), .rst(rst), .blank(blank), .sel_wr(sel_wr), .sel_data(sel_data),
  .ref_clk(ref_clk), .shift_clk(shift_clk), .vid_clk(vid_clk),
  .ref_code(ref_code), .vid_code(vid_code)
);

// File: tb/dotclk_divider_test.sv
`timescale 1ns/1ps
module dotclk_divider_test;
  typedef struct {
    string tag;
    int    val;
  } item_t;

  logic       dot_clk = 1'b0;
  logic       rst = 1'b1;
  logic       blank = 1'b0;
  logic       sel_wr = 1'b0;
  logic [5:0] sel_data = 6'h00;
  logic       ref_clk, shift_clk, vid_clk;

  item_t exp_q[$];
  int    act_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  dotclk_divider uut (
    .dot_clk(dot_clk), .rst(rst), .blank(blank), .sel_wr(sel_wr), .sel_data(sel_data),
    .ref_clk(ref_clk), .shift_clk(shift_clk), .vid_clk(vid_clk)
  );

  always #10 dot_clk = ~dot_clk;

  // Monitor: pairs each expected item with the next observed value.
  initial begin
    forever begin
      @(negedge dot_clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t e;
        int    a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_cmp++;
        if (a != e.val) begin
          n_bad++;
          $display("FAIL %s: actual %0d expected %0d", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    exp_q.push_back('{tag: tag, val: exp_v});
    act_q.push_back(act);
  endtask

  function automatic logic pick(input int which);
    if (which == 0) return ref_clk;
    if (which == 1) return shift_clk;
    return vid_clk;
  endfunction

  task automatic write_sel(input logic [5:0] v);
    @(negedge dot_clk); #2;
    sel_wr = 1'b1; sel_data = v;
    @(negedge dot_clk); #2;
    sel_wr = 1'b0;
    repeat (4) @(negedge dot_clk);
  endtask

  // Counts rising transitions over exactly ncyc dot cycles at half-cycle resolution.
  task automatic measure(input int which, input int ncyc, output int rises, output int level);
    logic prev, cur;
    rises = 0;
    @(negedge dot_clk); #5;
    prev = pick(which);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge dot_clk); #5;
      cur = pick(which);
      if (!prev && cur) rises++;
      prev = cur;
      @(negedge dot_clk); #5;
      cur = pick(which);
      if (!prev && cur) rises++;
      prev = cur;
    end
    level = int'(prev);
  endtask

  initial begin
    repeat (150000) @(posedge dot_clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int r, lv, mis, aligned;
    logic a0, a1, pr, pv;
    repeat (4) @(posedge dot_clk);
    @(negedge dot_clk); #2;
    rst = 1'b0;
    repeat (3) @(negedge dot_clk);

    // R1 reset state
    measure(0, 128, r, lv); chk("R1 ref rises", r, 2);
    measure(1, 128, r, lv); chk("R1 shift rises", r, 0); chk("R1 shift level", lv, 0);
    measure(2, 128, r, lv); chk("R1 vid rises", r, 0);   chk("R1 vid level", lv, 1);

    // R10 write takes effect: ref to divide by 2
    @(negedge dot_clk); #2;
    sel_wr = 1'b1; sel_data = {3'd6, 3'd1};
    @(posedge dot_clk); #5; a0 = ref_clk;
    @(negedge dot_clk); #2; sel_wr = 1'b0;
    @(posedge dot_clk); #5; a1 = ref_clk;
    chk("R10 ref toggles after write", int'(a0 != a1), 1);

    // R2 reference rates, R7 shift off at code 7
    for (int k = 0; k < 8; k++) begin
      write_sel({3'd6, 3'(k)});
      measure(0, 128, r, lv);
      chk($sformatf("R2 ref code %0d", k), r, 128 >> ((k > 6) ? 6 : k));
    end
    measure(1, 128, r, lv);
    chk("R7 shift rises at code 7", r, 0); chk("R7 shift level", lv, 0);

    // R3 video rates
    for (int k = 0; k < 8; k++) begin
      write_sel({3'(k), 3'd2});
      measure(2, 128, r, lv);
      chk($sformatf("R3 vid code %0d", k), r, (k == 7) ? 0 : (128 >> k));
    end
    chk("R3 vid held level", lv, 1);

    // R6 shift follows ref when not blanked
    write_sel({3'd7, 3'd2});
    measure(1, 128, r, lv); chk("R6 shift rises div4", r, 32);
    mis = 0;
    for (int i = 0; i < 32; i++) begin
      @(posedge dot_clk); #5;
      if (shift_clk != ref_clk) mis++;
      @(negedge dot_clk); #5;
      if (shift_clk != ref_clk) mis++;
    end
    chk("R6 shift equals ref", mis, 0);

    // R9 blank stops shift, R5 ref keeps running
    @(negedge dot_clk); #2; blank = 1'b1;
    repeat (10) @(negedge dot_clk);
    measure(1, 128, r, lv); chk("R9 shift stopped in blank", r, 0); chk("R9 shift low", lv, 0);
    measure(0, 128, r, lv); chk("R5 ref runs in blank", r, 32);
    @(negedge dot_clk); #2; blank = 1'b0;
    repeat (10) @(negedge dot_clk);
    measure(1, 128, r, lv); chk("R9 shift resumes", r, 32);

    // R9 with undivided reference
    write_sel({3'd7, 3'd0});
    @(negedge dot_clk); #2; blank = 1'b1;
    repeat (10) @(negedge dot_clk);
    measure(1, 64, r, lv); chk("R9 div1 shift stopped", r, 0);
    measure(0, 64, r, lv); chk("R5 div1 ref runs", r, 64);
    @(negedge dot_clk); #2; blank = 1'b0;
    repeat (10) @(negedge dot_clk);
    measure(1, 64, r, lv); chk("R9 div1 shift resumes", r, 64);

    // R8 clear: ref div2, vid div4
    write_sel({3'd2, 3'd1});
    @(negedge dot_clk); #2;
    sel_wr = 1'b1; sel_data = 6'h3F;
    @(posedge dot_clk); #5;
    chk("R8 ref low after clear", int'(ref_clk), 0);
    chk("R8 vid low after clear", int'(vid_clk), 0);
    @(negedge dot_clk); #2; sel_wr = 1'b0;
    @(posedge dot_clk); #5;
    chk("R8 ref rises next edge", int'(ref_clk), 1);
    chk("R8 vid rises next edge", int'(vid_clk), 1);
    @(posedge dot_clk); #5;
    chk("R8 ref step2", int'(ref_clk), 0); chk("R8 vid step2", int'(vid_clk), 1);
    @(posedge dot_clk); #5;
    chk("R8 ref step3", int'(ref_clk), 1); chk("R8 vid step3", int'(vid_clk), 0);
    measure(0, 128, r, lv); chk("R8 ref rate kept", r, 64);
    measure(2, 128, r, lv); chk("R8 vid rate kept", r, 32);

    // R4 rising-edge alignment: ref div2, vid div8
    write_sel({3'd3, 3'd1});
    mis = 0; aligned = 0;
    @(posedge dot_clk); #5; pr = ref_clk; pv = vid_clk;
    for (int i = 0; i < 64; i++) begin
      @(posedge dot_clk); #5;
      if (!pv && vid_clk) begin
        if (!pr && ref_clk) aligned++;
        else mis++;
      end
      pr = ref_clk; pv = vid_clk;
    end
    chk("R4 misaligned vid rises", mis, 0);
    chk("R4 aligned vid rises", aligned, 8);

    repeat (3) @(negedge dot_clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule